// File: doc/BRIEF.md
# Dual-Path Controller Ownership Unit

This unit guards a peripheral controller that two processors can reach, each over its own I/O channel port. Exactly one port owns the controller at any moment. A one-bit owner register records which one it is. Each port carries its own jumper-style controller number. A command is only seen by a port when the address on that port equals that port's number. Transfer commands (data or control) pass to the device datapath only when they arrive on the owned port. When they arrive on the other port, the unit answers with a distinct "owned elsewhere" status.

Two special commands manage the paths. The first claims ownership: it moves ownership to the issuing port, re-enables that port if it had been cut off, and pulses the controller reset. The second cuts off a port: it logically disconnects the issuing port and leaves ownership unchanged. A cut-off port ignores everything except a claim.

A raw power-good input is synchronized and then debounced before it has any effect. While power is not good, both port drivers are held off and the controller is held in reset. On a stable power-up, the controller reset is stretched and a one-cycle power-on interrupt goes to port 0.

Commands enter on a valid/ready handshake per port. `cmd_ready` is low while power is not good or while the controller reset runs. When port 0 presents a claim, port 1's ready is also low in that cycle. Responses and forwarded transfers are one-cycle pulses and take no back-pressure.

Top module: `dual_path_owner`

## Requirements
- R1: While the filtered power-good is low, `drv_en` is 00, `cmd_ready` is 00 and `ctl_reset` is 1. While it is high, `drv_en[p]` is 1 exactly when port p is not cut off.
- R2: `pwr_good_in` passes through a two-flop synchronizer. The filtered level changes only after the synchronized value has differed from it on FILT_LEN consecutive clock edges. A shorter pulse has no effect.
- R3: On a filtered power-good rise, `ctl_reset` stays high for RST_LEN further cycles and `pon_irq` is 01 for one cycle. Losing power returns ownership to port 0 and clears both cut-offs.
- R4: A handshake on port p counts only when that port's address equals that port's configured number. Any other handshake gives no response and forwards nothing.
- R5: Opcodes are 00 data, 01 control, 10 claim and 11 cut-off. A data or control command on the owned, enabled port does two things one cycle later. It answers with `rsp_valid[p]` and status 00. It raises `fwd_valid`, with `fwd_port` set to the port and `fwd_op` set to opcode bit 0.
- R6: A data or control command on the enabled, non-owned port answers with status 01 one cycle later and forwards nothing.
- R7: A claim sets `owner` to the issuing port, re-enables that port and answers status 00. It starts a controller reset of RST_LEN cycles, visible from the next cycle.
- R8: A cut-off answers status 00, disables the issuing port and does not change `owner`. A cut-off port gives no response to data, control or cut-off commands.
- R9: `cmd_ready` is low while `ctl_reset` is high. When both ports present a claim in the same cycle, port 0 wins because port 1's ready is low. A cycle that accepts a claim forwards nothing.
- R10: `owner` changes only through an accepted claim or a loss of power.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good_in | input | 1 | Raw, asynchronous power-good level |
| cfg_id0 | input | ADDR_W | Controller number of port 0 |
| cfg_id1 | input | ADDR_W | Controller number of port 1 |
| cmd_valid | input | 2 | Command valid, one bit per port |
| cmd_ready | output | 2 | Command ready, one bit per port |
| cmd_addr0 | input | ADDR_W | Address on port 0 |
| cmd_addr1 | input | ADDR_W | Address on port 1 |
| cmd_op0 | input | 2 | Opcode on port 0 |
| cmd_op1 | input | 2 | Opcode on port 1 |
| rsp_valid | output | 2 | Response pulse per port |
| rsp_status0 | output | 2 | Port 0 status: 00 ok, 01 owned elsewhere |
| rsp_status1 | output | 2 | Port 1 status: 00 ok, 01 owned elsewhere |
| fwd_valid | output | 1 | Transfer forwarded to the datapath |
| fwd_port | output | 1 | Port the transfer came from |
| fwd_op | output | 1 | 0 data, 1 control |
| owner | output | 1 | Index of the owned port |
| drv_en | output | 2 | Port transceiver enables |
| ctl_reset | output | 1 | Controller reset |
| pon_irq | output | 2 | Power-on interrupt, one bit per port |

## Verification
The bench builds the unit with FILT_LEN 3 and RST_LEN 2, so every debounce window and reset stretch lasts only a few cycles. With these values a two-cycle glitch lies one edge short of the threshold, and repeated claims, cut-offs and power cycles fit in a short run. The two ports get different controller numbers, 9 and 22, so a command carrying the other port's number is exercised as a mismatch. Same-cycle claims on both ports, and a claim that collides with a transfer on the owned port, are driven on purpose to exercise the port-0 priority and the suppression of forwarding.

// File: rtl/dpo_pkg.sv
package dpo_pkg;
  typedef enum logic [1:0] {
    OP_DATA  = 2'b00,
    OP_CTRL  = 2'b01,
    OP_CLAIM = 2'b10,
    OP_CUT   = 2'b11
  } dpo_op_e;

  typedef enum logic [1:0] {
    ST_OK    = 2'b00,
    ST_OTHER = 2'b01
  } dpo_st_e;
endpackage

// File: rtl/dpo_pg_filter.sv
module dpo_pg_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic level,
  output logic rise
);
  localparam int CW = $clog2(FILT_LEN) + 1;

  logic          sync1, sync2;
  logic [CW-1:0] run;
  logic          fire;

  assign fire = (sync2 != level) && (run == CW'(FILT_LEN - 1));
  assign rise = fire && sync2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      run   <= '0;
      level <= 1'b0;
    end else begin
      sync1 <= raw_in;
      sync2 <= sync1;
      if (sync2 != level) begin
        if (fire) begin
          run   <= '0;
          level <= sync2;
        end else begin
          run <= run + 1'b1;
        end
      end else begin
        run <= '0;
      end
    end
  end

  assert_level_follows_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (level != $past(level)) |-> (level == $past(sync2)));
endmodule

// File: rtl/dpo_port_dec.sv
module dpo_port_dec
  import dpo_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] my_id,
  output logic              hit,
  output logic              is_claim,
  output logic              is_cut,
  output logic              is_xfer
);
  always_comb begin
    hit      = valid && (addr == my_id);
    is_claim = (op == OP_CLAIM);
    is_cut   = (op == OP_CUT);
    is_xfer  = (op == OP_DATA) || (op == OP_CTRL);
  end
endmodule

// File: rtl/dpo_rst_timer.sv
module dpo_rst_timer #(
  parameter int RST_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pg_ok,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(RST_LEN + 1);

  logic [CW-1:0] left;

  assign busy = (left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
    end else if (start) begin
      left <= CW'(RST_LEN);
    end else if (!pg_ok) begin
      left <= '0;
    end else if (busy) begin
      left <= left - 1'b1;
    end
  end

  assert_start_gives_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/dual_path_owner.sv
module dual_path_owner
  import dpo_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int FILT_LEN = 4,
  parameter int RST_LEN  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good_in,
  input  logic [ADDR_W-1:0] cfg_id0,
  input  logic [ADDR_W-1:0] cfg_id1,
  input  logic [1:0]        cmd_valid,
  output logic [1:0]        cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr0,
  input  logic [ADDR_W-1:0] cmd_addr1,
  input  logic [1:0]        cmd_op0,
  input  logic [1:0]        cmd_op1,
  output logic [1:0]        rsp_valid,
  output logic [1:0]        rsp_status0,
  output logic [1:0]        rsp_status1,
  output logic              fwd_valid,
  output logic              fwd_port,
  output logic              fwd_op,
  output logic              owner,
  output logic [1:0]        drv_en,
  output logic              ctl_reset,
  output logic [1:0]        pon_irq
);
  localparam int NPORT = 2;

  logic                 pg_ok, pg_rise, rst_busy;
  logic [ADDR_W-1:0]    addr_v [NPORT];
  logic [ADDR_W-1:0]    id_v   [NPORT];
  logic [1:0]           op_v   [NPORT];
  logic [NPORT-1:0]     hit, is_claim, is_cut, is_xfer;
  logic [NPORT-1:0]     acc, live, win, cut_off;
  logic                 base_rdy, claim_any;
  logic [1:0]           status_q [NPORT];
  logic                 xfer_owned;

  assign addr_v[0] = cmd_addr0;
  assign addr_v[1] = cmd_addr1;
  assign id_v[0]   = cfg_id0;
  assign id_v[1]   = cfg_id1;
  assign op_v[0]   = cmd_op0;
  assign op_v[1]   = cmd_op1;

  dpo_pg_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .raw_in(pwr_good_in), .level(pg_ok), .rise(pg_rise)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_dec
    dpo_port_dec #(.ADDR_W(ADDR_W)) u_dec (
      .valid(cmd_valid[p]), .addr(addr_v[p]), .op(op_v[p]), .my_id(id_v[p]),
      .hit(hit[p]), .is_claim(is_claim[p]), .is_cut(is_cut[p]), .is_xfer(is_xfer[p])
    );
  end

  always_comb begin
    base_rdy     = pg_ok && !rst_busy;
    cmd_ready[0] = base_rdy;
    cmd_ready[1] = base_rdy && !(hit[0] && is_claim[0]);
    acc          = hit & cmd_ready;
    live         = acc & (~cut_off | is_claim);
    win          = live & is_claim;
    claim_any    = |win;
    xfer_owned   = live[owner] && is_xfer[owner];
  end

  dpo_rst_timer #(.RST_LEN(RST_LEN)) u_rst (
    .clk(clk), .rst_n(rst_n), .pg_ok(pg_ok),
    .start(pg_rise || (pg_ok && claim_any)), .busy(rst_busy)
  );

  assign ctl_reset   = !pg_ok || rst_busy;
  assign drv_en      = {NPORT{pg_ok}} & ~cut_off;
  assign rsp_status0 = status_q[0];
  assign rsp_status1 = status_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner     <= 1'b0;
      cut_off   <= '0;
      rsp_valid <= '0;
      fwd_valid <= 1'b0;
      fwd_port  <= 1'b0;
      fwd_op    <= 1'b0;
      pon_irq   <= '0;
      for (int p = 0; p < NPORT; p++) status_q[p] <= ST_OK;
    end else if (!pg_ok) begin
      owner     <= 1'b0;
      cut_off   <= '0;
      rsp_valid <= '0;
      fwd_valid <= 1'b0;
      pon_irq   <= pg_rise ? 2'b01 : 2'b00;
    end else begin
      pon_irq <= '0;
      if (win[1])      owner <= 1'b1;
      else if (win[0]) owner <= 1'b0;
      for (int p = 0; p < NPORT; p++) begin
        if (win[p])                   cut_off[p] <= 1'b0;
        else if (live[p] && is_cut[p]) cut_off[p] <= 1'b1;
        rsp_valid[p] <= live[p];
        status_q[p]  <= (live[p] && is_xfer[p] && (owner != 1'(p))) ? ST_OTHER : ST_OK;
      end
      fwd_valid <= xfer_owned && !claim_any;
      fwd_port  <= owner;
      fwd_op    <= op_v[owner][0];
    end
  end

  assert_owner_only_by_claim_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_ok && !claim_any) |=> $stable(owner));

  assert_fwd_from_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (fwd_port == owner));

  assert_reject_not_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid[0] && rsp_status0 == ST_OTHER) |-> (owner != 1'b0));

  assert_irq_after_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|pon_irq) |-> ($onehot0(pon_irq) && !$past(pg_ok)));

  assert_no_ready_in_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset |-> (cmd_ready == 2'b00));

  assert_claim_resets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_ok && claim_any) |=> ctl_reset);
endmodule

// File: tb/dual_path_owner_bench.sv
`timescale 1ns/1ps
module dual_path_owner_bench;
  localparam int AW = 5;
  localparam int FL = 3;
  localparam int RL = 2;
  localparam logic [AW-1:0] ID0 = 5'd9;
  localparam logic [AW-1:0] ID1 = 5'd22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pg_raw = 1'b0;
  logic [1:0] cmd_valid = 2'b00;
  logic [AW-1:0] cmd_addr0 = '0, cmd_addr1 = '0;
  logic [1:0] cmd_op0 = 2'b00, cmd_op1 = 2'b00;
  logic [1:0] cmd_ready, rsp_valid, rsp_status0, rsp_status1, drv_en, pon_irq;
  logic fwd_valid, fwd_port, fwd_op, owner, ctl_reset;

  int checks = 0;
  int errors = 0;
  int irq_seen = 0;

  always #2 clk = ~clk;

  dual_path_owner #(.ADDR_W(AW), .FILT_LEN(FL), .RST_LEN(RL)) u_dual_path_owner (
    .clk(clk), .rst_n(rst_n), .pwr_good_in(pg_raw), .cfg_id0(ID0), .cfg_id1(ID1),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr0(cmd_addr0),
    .cmd_addr1(cmd_addr1), .cmd_op0(cmd_op0), .cmd_op1(cmd_op1),
    .rsp_valid(rsp_valid), .rsp_status0(rsp_status0), .rsp_status1(rsp_status1),
    .fwd_valid(fwd_valid), .fwd_port(fwd_port), .fwd_op(fwd_op), .owner(owner),
    .drv_en(drv_en), .ctl_reset(ctl_reset), .pon_irq(pon_irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  int m_s1, m_s2, m_cnt, m_pg, m_own, m_rc, m_fv, m_fp, m_fo, m_irq;
  int m_dis[2], m_rv[2], m_st[2];

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_cnt = 0; m_pg = 0; m_own = 0; m_rc = 0;
    m_fv = 0; m_fp = 0; m_fo = 0; m_irq = 0;
    for (int p = 0; p < 2; p++) begin m_dis[p] = 0; m_rv[p] = 0; m_st[p] = 0; end
  endtask

  function automatic int rdy(int p);
    int base;
    base = (m_pg == 1 && m_rc == 0) ? 1 : 0;
    if (p == 1 && cmd_valid[0] && cmd_addr0 == ID0 && cmd_op0 == 2'b10) return 0;
    return base;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int acc[2], op[2], live[2], tw, fire, rise;
      op[0] = cmd_op0; op[1] = cmd_op1;
      acc[0] = (cmd_valid[0] && cmd_addr0 == ID0 && rdy(0) == 1) ? 1 : 0;
      acc[1] = (cmd_valid[1] && cmd_addr1 == ID1 && rdy(1) == 1) ? 1 : 0;
      tw = -1;
      for (int p = 0; p < 2; p++) begin
        live[p] = (acc[p] == 1 && (m_dis[p] == 0 || op[p] == 2)) ? 1 : 0;
        if (live[p] == 1 && op[p] == 2 && tw < 0) tw = p;
      end
      fire = (m_s2 != m_pg && m_cnt == FL - 1) ? 1 : 0;
      rise = (fire == 1 && m_s2 == 1) ? 1 : 0;
      if (m_pg == 0) begin
        m_own = 0; m_dis[0] = 0; m_dis[1] = 0; m_rv[0] = 0; m_rv[1] = 0; m_fv = 0;
        m_irq = rise; m_rc = rise == 1 ? RL : 0;
      end else begin
        int own0;
        own0 = m_own;
        m_irq = 0;
        m_fv = 0;
        for (int p = 0; p < 2; p++) begin
          m_rv[p] = live[p];
          m_st[p] = 0;
          if (live[p] == 1) begin
            if (op[p] == 2) m_dis[p] = 0;
            else if (op[p] == 3) m_dis[p] = 1;
            else if (p != own0) m_st[p] = 1;
            else if (tw < 0) begin m_fv = 1; m_fp = p; m_fo = op[p] & 1; end
          end
        end
        if (tw >= 0) begin m_own = tw; m_rc = RL; end
        else if (m_rc > 0) m_rc--;
      end
      if (m_s2 != m_pg) m_cnt = fire == 1 ? 0 : m_cnt + 1; else m_cnt = 0;
      if (fire == 1) m_pg = m_s2;
      m_s2 = m_s1;
      m_s1 = pg_raw;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int ed;
      check(cmd_ready == 2'(rdy(1) * 2 + rdy(0)), "R9 cmd_ready", cmd_ready, rdy(1) * 2 + rdy(0));
      ed = (m_pg == 1) ? ((1 - m_dis[1]) * 2 + (1 - m_dis[0])) : 0;
      check(drv_en == 2'(ed), "R1 drv_en", drv_en, ed);
      check(ctl_reset == (m_pg == 0 || m_rc != 0), "R3 ctl_reset", ctl_reset, (m_pg == 0 || m_rc != 0));
      check(owner == 1'(m_own), "R10 owner", owner, m_own);
      check(rsp_valid == 2'(m_rv[1] * 2 + m_rv[0]), "R5 rsp_valid", rsp_valid, m_rv[1] * 2 + m_rv[0]);
      if (rsp_valid[0]) check(rsp_status0 == 2'(m_st[0]), "R6 status0", rsp_status0, m_st[0]);
      if (rsp_valid[1]) check(rsp_status1 == 2'(m_st[1]), "R6 status1", rsp_status1, m_st[1]);
      check(fwd_valid == 1'(m_fv), "R5 fwd_valid", fwd_valid, m_fv);
      if (fwd_valid) check({fwd_port, fwd_op} == 2'(m_fp * 2 + m_fo), "R5 fwd fields",
                           {fwd_port, fwd_op}, m_fp * 2 + m_fo);
      check(pon_irq == 2'(m_irq), "R3 pon_irq", pon_irq, m_irq);
      if (pon_irq[0]) irq_seen++;
    end
  end

  task automatic send2(input bit v0, input logic [AW-1:0] a0, input logic [1:0] o0,
                       input bit v1, input logic [AW-1:0] a1, input logic [1:0] o1);
    cmd_valid = {v1, v0};
    cmd_addr0 = a0; cmd_op0 = o0; cmd_addr1 = a1; cmd_op1 = o1;
    @(negedge clk);
    cmd_valid = 2'b00;
  endtask

  task automatic send(input int p, input logic [AW-1:0] a, input logic [1:0] o);
    if (p == 0) send2(1'b1, a, o, 1'b0, '0, 2'b00);
    else        send2(1'b0, '0, 2'b00, 1'b1, a, o);
  endtask

  task automatic settle();
    int n = 0;
    while (ctl_reset && n < 100) begin @(negedge clk); n++; end
  endtask

  bit done = 0;
  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ctl_reset == 1'b1 && drv_en == 2'b00 && cmd_ready == 2'b00, "R1 reset state", drv_en, 0);

    pg_raw = 1'b1; repeat (2) @(negedge clk); pg_raw = 1'b0;
    repeat (8) @(negedge clk);
    check(drv_en == 2'b00 && ctl_reset, "R2 glitch ignored", drv_en, 0);

    pg_raw = 1'b1; repeat (8) @(negedge clk); settle();
    check(drv_en == 2'b11 && owner == 1'b0, "R3 power up", drv_en, 3);
    check(irq_seen == 1, "R3 irq count", irq_seen, 1);

    send(0, ID0, 2'b00);
    check(rsp_valid[0] && rsp_status0 == 2'b00 && fwd_valid && !fwd_port && !fwd_op, "R5 owned data", fwd_valid, 1);
    send(0, ID0 ^ 5'd1, 2'b01);
    check(rsp_valid == 2'b00 && !fwd_valid, "R4 wrong number", rsp_valid, 0);
    send(0, ID1, 2'b00);
    check(rsp_valid == 2'b00 && !fwd_valid, "R4 other port number", rsp_valid, 0);
    send(1, ID1, 2'b01);
    check(rsp_valid[1] && rsp_status1 == 2'b01 && !fwd_valid, "R6 reject", rsp_status1, 1);

    send(1, ID1, 2'b10);
    check(rsp_valid[1] && rsp_status1 == 2'b00 && owner && ctl_reset, "R7 claim", owner, 1);
    check(cmd_ready == 2'b00, "R9 ready during reset", cmd_ready, 0);
    settle();
    send(1, ID1, 2'b01);
    check(fwd_valid && fwd_port && fwd_op, "R5 new owner control", {fwd_port, fwd_op}, 3);
    send(0, ID0, 2'b00);
    check(rsp_valid[0] && rsp_status0 == 2'b01, "R6 old owner rejected", rsp_status0, 1);

    send(0, ID0, 2'b11);
    check(rsp_valid[0] && drv_en == 2'b10 && owner, "R8 cut-off", drv_en, 2);
    send(0, ID0, 2'b00);
    check(rsp_valid == 2'b00 && !fwd_valid, "R8 cut port silent", rsp_valid, 0);
    send(0, ID0, 2'b10);
    check(!owner == 1'b1 && rsp_valid[0], "R7 claim re-enables", owner, 0);
    settle();
    check(drv_en == 2'b11, "R7 port back", drv_en, 3);

    send2(1'b1, ID0, 2'b10, 1'b1, ID1, 2'b10);
    check(owner == 1'b0 && rsp_valid == 2'b01, "R9 port0 priority", rsp_valid, 1);
    settle();
    send2(1'b1, ID0, 2'b00, 1'b1, ID1, 2'b10);
    check(owner == 1'b1 && !fwd_valid, "R9 claim blocks forward", fwd_valid, 0);
    settle();

    send(1, ID1, 2'b11);
    check(owner == 1'b1 && drv_en == 2'b01, "R10 cut owner keeps ownership", owner, 1);
    send(0, ID0, 2'b00);
    check(rsp_valid[0] && rsp_status0 == 2'b01, "R6 still not owner", rsp_status0, 1);
    send(1, ID1, 2'b00);
    check(rsp_valid == 2'b00, "R8 cut owner silent", rsp_valid, 0);

    pg_raw = 1'b0; repeat (8) @(negedge clk);
    check(drv_en == 2'b00 && ctl_reset && cmd_ready == 2'b00, "R1 power lost", drv_en, 0);
    pg_raw = 1'b1; repeat (8) @(negedge clk); settle();
    check(owner == 1'b0 && drv_en == 2'b11, "R3 state cleared", drv_en, 3);
    check(irq_seen == 2, "R3 second irq", irq_seen, 2);

    repeat (4) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule